// File: doc/BRIEF.md
# Deferred-Read Register Bridge

This block sits on the peripheral side of a serial control bus and turns byte-wide register accesses into accesses on an internal memory map. Most of that map is fast register space. Reads and writes to it pass straight through, and read data comes back in the same cycle as the bus read strobe. Part of the map is a slow one-time-programmable region. Its access latency is longer than the bus allows for a response, so data from it is never returned in the bus response itself.

A read of a slow word therefore works in several steps. The bus master reads the lowest byte of the word. That read returns zero and launches a fetch on a request/acknowledge memory port whose latency can vary. The master then polls a bridge status register until the data-ready flag is set. It then reads the fetched word, one byte at a time, from a separately addressed holding register. Reading the top byte of the holding register marks the buffer as consumed.

Bus addresses sit a fixed offset above internal addresses. The bridge's own registers live below that offset.

Top module: `late_read_bridge`

## Requirements
- R1: After reset the status byte reads 0x00 and `mem_req_o` is low.
- R2: A bus read at an address of 0x8000 or above whose internal address (bus address minus 0x8000) has bits [31:16] not equal to 3 drives `fast_rd_o` high with `fast_addr_o` set to the internal address. In the same cycle, `bus_rdata_o` equals `fast_rdata_i`.
- R3: A bus write to such a fast address drives `fast_wr_o` high in the same cycle, with `fast_addr_o` set to the internal address and `fast_wdata_o` equal to `bus_wdata_i`.
- R4: A bus read of a slow address (internal bits [31:16] equal to 3) whose internal bits [1:0] are 0 returns 0 and launches a fetch. From the next cycle, `mem_req_o` is high and stays high with a stable `mem_addr_o`, which equals the internal address, until `mem_ack_i` is seen. The status byte then shows busy (bit 2) set and ready (bit 0) clear.
- R5: A cycle with `mem_ack_i` high during a fetch captures `mem_rdata_i` into the holding register. In the next cycle, busy is clear, ready is set and `mem_req_o` is low.
- R6: Bus address 0xD8+k (k = 0..3) reads holding-register bits [8k+7:8k].
- R7: A read of 0xDB clears ready. Reads of 0xD8 to 0xDA, and reads of the status byte, leave it set.
- R8: A launch clears ready. Ready and busy are never set together.
- R9: A launch read that arrives while busy is ignored: `mem_addr_o` and the fetch already running are unchanged. It sets the late flag (status bit 3). The next accepted launch clears that flag.
- R10: Slow-region reads whose internal bits [1:0] are not 0, and all slow-region writes, launch nothing, return 0 on reads, and leave `fast_rd_o`/`fast_wr_o` low.
- R11: The status byte is read at bus address 0xD0, with ready at bit 0, busy at bit 2, late at bit 3 and all other bits 0. Bridge registers are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_rd_i | input | 1 | Bus read strobe, one cycle |
| bus_wr_i | input | 1 | Bus write strobe, one cycle |
| bus_addr_i | input | 32 | Bus byte address |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data, valid in the strobe cycle |
| fast_rd_o | output | 1 | Fast-region read strobe |
| fast_wr_o | output | 1 | Fast-region write strobe |
| fast_addr_o | output | 32 | Internal byte address |
| fast_wdata_o | output | 8 | Fast-region write data |
| fast_rdata_i | input | 8 | Fast-region read data, combinational |
| mem_req_o | output | 1 | Slow fetch request, held until acknowledged |
| mem_addr_o | output | 32 | Word-aligned internal address of the fetch |
| mem_ack_i | input | 1 | Fetch acknowledge with data |
| mem_rdata_i | input | 32 | Fetched word |

## Verification
The assertions check the following on every cycle: the request stays held with a stable address until acknowledged, ready and busy are never set together, an acknowledge or launch moves the flags as required, a busy launch marks late without moving the address, and slow accesses never strobe the fast port. Only the bench scenarios can show the rest, because it depends on values and on sequences of several accesses. This covers the correct word reaching each holding byte lane, the exact internal address of a fetch under randomly varied memory latency, the late flag clearing on the next accepted launch, and fast-path data matching a memory model.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
  localparam int STAT_RDY_BIT  = 0;
  localparam int STAT_BUSY_BIT = 2;
  localparam int STAT_LATE_BIT = 3;

  typedef struct packed {
    logic late;
    logic busy;
    logic rdy;
  } lrb_status_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_FAST,
    SEL_SLOW,
    SEL_BRIDGE
  } lrb_region_e;
endpackage

// File: rtl/lrb_decode.sv
module lrb_decode
  import lrb_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          WORD_BYTES = 4,
  parameter int          SEL_LSB    = 16,
  parameter logic [31:0] BUS_OFFSET = 32'h0000_8000,
  parameter logic [31:0] SLOW_SEL   = 32'h3,
  parameter logic [31:0] STAT_ADDR  = 32'hD0,
  parameter logic [31:0] RDAT_ADDR  = 32'hD8,
  localparam int         LSB_W      = $clog2(WORD_BYTES)
) (
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [ADDR_W-1:0] int_addr_o,
  output lrb_region_e       region_o,
  output logic              slow_lsb_o,
  output logic              is_stat_o,
  output logic              is_rdat_o,
  output logic [LSB_W-1:0]  rdat_idx_o,
  output logic              rdat_last_o
);
  localparam int SEL_W = ADDR_W - SEL_LSB;
  localparam logic [ADDR_W-1:0] OFS  = BUS_OFFSET[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] STAT = STAT_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] RDAT = RDAT_ADDR[ADDR_W-1:0];
  localparam logic [SEL_W-1:0]  SSEL = SLOW_SEL[SEL_W-1:0];

  logic in_bridge;

  always_comb begin
    in_bridge  = bus_addr_i < OFS;
    int_addr_o = bus_addr_i - OFS;
    if (in_bridge)                                 region_o = SEL_BRIDGE;
    else if (int_addr_o[ADDR_W-1:SEL_LSB] == SSEL) region_o = SEL_SLOW;
    else                                           region_o = SEL_FAST;
    slow_lsb_o  = (region_o == SEL_SLOW) && (int_addr_o[LSB_W-1:0] == '0);
    is_stat_o   = in_bridge && (bus_addr_i == STAT);
    is_rdat_o   = in_bridge && (bus_addr_i[ADDR_W-1:LSB_W] == RDAT[ADDR_W-1:LSB_W]);
    rdat_idx_o  = bus_addr_i[LSB_W-1:0];
    rdat_last_o = is_rdat_o && (rdat_idx_o == LSB_W'(WORD_BYTES - 1));
  end
endmodule

// File: rtl/lrb_fetch.sv
module lrb_fetch
  import lrb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int BYTE_W     = 8,
  localparam int WORD_W    = WORD_BYTES * BYTE_W,
  localparam int LSB_W     = $clog2(WORD_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] launch_addr_i,
  input  logic              rd_last_i,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output lrb_status_t       status_o,
  output logic [WORD_W-1:0] hold_o
);
  logic rdy_q, busy_q, late_q;
  logic accept, done;

  assign accept = launch_i && !busy_q;
  assign done   = busy_q && mem_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q      <= 1'b0;
      busy_q     <= 1'b0;
      late_q     <= 1'b0;
      mem_addr_o <= '0;
      hold_o     <= '0;
    end else begin
      if (accept) begin
        busy_q     <= 1'b1;
        rdy_q      <= 1'b0;
        late_q     <= 1'b0;
        mem_addr_o <= {launch_addr_i[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
      end else if (done) begin
        busy_q <= 1'b0;
        rdy_q  <= 1'b1;
        hold_o <= mem_rdata_i;
      end else if (rd_last_i) begin
        rdy_q <= 1'b0;
      end
      if (launch_i && busy_q) late_q <= 1'b1;
    end
  end

  assign mem_req_o = busy_q;
  assign status_o  = '{late: late_q, busy: busy_q, rdy: rdy_q};

  a_r4_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  a_r5_ack_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> status_o.rdy && !mem_req_o);
  a_r7_last_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_i && !(mem_req_o && mem_ack_i) |=> !status_o.rdy);
  a_r8_launch_clears_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && !mem_req_o |=> !status_o.rdy && mem_req_o);
  a_r8_rdy_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o.rdy && status_o.busy));
  a_r9_busy_marks_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && mem_req_o |=> status_o.late && $stable(mem_addr_o));
endmodule

// File: rtl/late_read_bridge.sv
module late_read_bridge
  import lrb_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          BYTE_W     = 8,
  parameter int          WORD_BYTES = 4,
  parameter int          SEL_LSB    = 16,
  parameter logic [31:0] BUS_OFFSET = 32'h0000_8000,
  parameter logic [31:0] SLOW_SEL   = 32'h3,
  parameter logic [31:0] STAT_ADDR  = 32'hD0,
  parameter logic [31:0] RDAT_ADDR  = 32'hD8,
  localparam int         WORD_W     = WORD_BYTES * BYTE_W,
  localparam int         LSB_W      = $clog2(WORD_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic              fast_rd_o,
  output logic              fast_wr_o,
  output logic [ADDR_W-1:0] fast_addr_o,
  output logic [BYTE_W-1:0] fast_wdata_o,
  input  logic [BYTE_W-1:0] fast_rdata_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  logic [ADDR_W-1:0] int_addr;
  lrb_region_e       region;
  logic              slow_lsb, is_stat, is_rdat, rdat_last;
  logic [LSB_W-1:0]  rdat_idx;
  lrb_status_t       status;
  logic [WORD_W-1:0] hold;
  logic [BYTE_W-1:0] hold_byte [WORD_BYTES];
  logic [BYTE_W-1:0] stat_byte;

  lrb_decode #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .SEL_LSB(SEL_LSB),
    .BUS_OFFSET(BUS_OFFSET), .SLOW_SEL(SLOW_SEL),
    .STAT_ADDR(STAT_ADDR), .RDAT_ADDR(RDAT_ADDR)
  ) u_decode (
    .bus_addr_i (bus_addr_i),
    .int_addr_o (int_addr),
    .region_o   (region),
    .slow_lsb_o (slow_lsb),
    .is_stat_o  (is_stat),
    .is_rdat_o  (is_rdat),
    .rdat_idx_o (rdat_idx),
    .rdat_last_o(rdat_last)
  );

  lrb_fetch #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .BYTE_W(BYTE_W)
  ) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (bus_rd_i && slow_lsb),
    .launch_addr_i(int_addr),
    .rd_last_i    (bus_rd_i && rdat_last),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .status_o     (status),
    .hold_o       (hold)
  );

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    assign hold_byte[k] = hold[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    stat_byte                = '0;
    stat_byte[STAT_RDY_BIT]  = status.rdy;
    stat_byte[STAT_BUSY_BIT] = status.busy;
    stat_byte[STAT_LATE_BIT] = status.late;
  end

  assign fast_rd_o    = bus_rd_i && (region == SEL_FAST);
  assign fast_wr_o    = bus_wr_i && (region == SEL_FAST);
  assign fast_addr_o  = int_addr;
  assign fast_wdata_o = bus_wdata_i;

  always_comb begin
    bus_rdata_o = '0;
    if (region == SEL_FAST)  bus_rdata_o = fast_rdata_i;
    else if (is_stat)        bus_rdata_o = stat_byte;
    else if (is_rdat)        bus_rdata_o = hold_byte[rdat_idx];
  end

  a_r10_slow_no_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region == SEL_SLOW) |-> !fast_rd_o && !fast_wr_o);
  a_r2_fast_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_rd_o |-> bus_rdata_o == fast_rdata_i);
endmodule

// File: tb/sim_late_read_bridge.sv
`timescale 1ns/1ps
module sim_late_read_bridge;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_rd_i = 1'b0, bus_wr_i = 1'b0;
  logic [31:0] bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        fast_rd_o, fast_wr_o;
  logic [31:0] fast_addr_o;
  logic [7:0]  fast_wdata_o, fast_rdata_i;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0, mem_hold = 0;
  int lat = 0, wcnt = 0;
  logic        c_frd, c_fwr;
  logic [31:0] c_faddr;
  logic [7:0]  c_fwd;

  always #10 clk_i = ~clk_i;

  late_read_bridge u0 (.*);

  function automatic logic [7:0] fast_model(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5C;
  endfunction
  function automatic logic [31:0] mem_model(logic [31:0] a);
    return a * 32'h9E37_79B1 + 32'h1234_5677;
  endfunction

  assign fast_rdata_i = fast_model(fast_addr_o);

  always @(negedge clk_i) begin
    if (mem_ack_i) mem_ack_i = 1'b0;
    else if (mem_req_o && !mem_hold) begin
      if (wcnt >= lat) begin
        mem_ack_i = 1'b1;
        mem_rdata_i = mem_model(mem_addr_o);
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_read(logic [31:0] a, output logic [7:0] d);
    bus_addr_i = a; bus_rd_i = 1'b1;
    #5;
    d = bus_rdata_o; c_frd = fast_rd_o; c_fwr = fast_wr_o; c_faddr = fast_addr_o;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
  endtask

  task automatic bus_write(logic [31:0] a, logic [7:0] v);
    bus_addr_i = a; bus_wdata_i = v; bus_wr_i = 1'b1;
    #5;
    c_frd = fast_rd_o; c_fwr = fast_wr_o; c_faddr = fast_addr_o; c_fwd = fast_wdata_o;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic wait_ready(string tag);
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      bus_read(32'hD0, s);
      if (s[0]) return;
    end
    check(tag, 0, 1);
  endtask

  task automatic read_hold(string tag, logic [31:0] exp);
    logic [7:0] d, s;
    for (int k = 0; k < 4; k++) begin
      bus_read(32'hD8 + k, d);
      check({tag, " R6 byte lane"}, d, exp[8*k +: 8]);
      bus_read(32'hD0, s);
      check({tag, " R7 ready after lane read"}, s[0], (k < 3) ? 1 : 0);
    end
  endtask

  function automatic logic [31:0] slow_int(logic [15:0] ofs);
    return {16'h0003, ofs[15:2], 2'b00};
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, s;
    logic [31:0] ia, ib, ic;
    void'($urandom(32'h1D5A));
    repeat (3) @(negedge clk_i);
    #3;
    bus_read(32'hD0, s);
    check("R1 status after reset", s, 8'h00);
    check("R1 request after reset", mem_req_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    bus_read(32'hD0, s);
    check("R1 R11 status idle", s, 8'h00);

    for (int i = 0; i < 20; i++) begin
      logic [31:0] a = $urandom();
      if (a[31:16] == 16'h3) a[31:16] = 16'h7;
      if (a > 32'hFFFF_7FFF) a[31] = 1'b0;
      bus_read(a + 32'h8000, d);
      check("R2 fast strobe", c_frd, 1);
      check("R2 fast address", c_faddr, a);
      check("R2 fast data", d, fast_model(a));
    end
    for (int i = 0; i < 6; i++) begin
      logic [31:0] a = {16'h0001, 16'($urandom())};
      logic [7:0] v = 8'($urandom());
      bus_write(a + 32'h8000, v);
      check("R3 fast write strobe", c_fwr, 1);
      check("R3 fast write address", c_faddr, a);
      check("R3 fast write data", c_fwd, v);
    end

    for (int i = 0; i < 10; i++) begin
      ia = slow_int(16'($urandom()));
      lat = $urandom_range(0, 12);
      bus_read(ia + 32'h8000, d);
      check("R4 launch read returns zero", d, 0);
      check("R10 no fast strobe on slow read", c_frd, 0);
      check("R4 request raised", mem_req_o, 1);
      check("R4 fetch address", mem_addr_o, ia);
      bus_read(32'hD0, s);
      check("R4 R11 status busy", s, 8'h04);
      wait_ready("R5 ready timeout");
      bus_read(32'hD0, s);
      check("R5 status ready only", s, 8'h01);
      check("R5 request dropped", mem_req_o, 0);
      read_hold("R5", mem_model(ia));
    end

    // busy launch ignored
    lat = 0;
    mem_hold = 1;
    ia = slow_int(16'h0100);
    ib = slow_int(16'h0204);
    bus_read(ia + 32'h8000, d);
    repeat (3) @(negedge clk_i);
    bus_read(ib + 32'h8000, d);
    check("R9 address kept", mem_addr_o, ia);
    bus_read(32'hD0, s);
    check("R9 status busy and late", s, 8'h0C);
    mem_hold = 0;
    wait_ready("R9 ready timeout");
    bus_read(32'hD0, s);
    check("R9 late persists after completion", s, 8'h09);
    bus_read(32'hD9, d);
    check("R9 first fetch data kept", d, mem_model(ia) >> 8 & 32'hFF);
    mem_hold = 1;
    ic = slow_int(16'h0308);
    bus_read(ic + 32'h8000, d);
    bus_read(32'hD0, s);
    check("R8 R9 launch clears ready and late", s, 8'h04);
    mem_hold = 0;
    wait_ready("R8 ready timeout");
    read_hold("R8", mem_model(ic));

    // slow non-LSB reads and writes
    for (int k = 1; k < 4; k++) begin
      bus_read(32'h8000 + slow_int(16'h0040) + k, d);
      check("R10 non-lsb read zero", d, 0);
      check("R10 no request", mem_req_o, 0);
    end
    bus_write(32'h8000 + slow_int(16'h0040), 8'hAA);
    check("R10 slow write no fast strobe", c_fwr, 0);
    check("R10 slow write no request", mem_req_o, 0);
    bus_write(32'hD0, 8'hFF);
    bus_read(32'hD0, s);
    check("R11 status read-only", s, 8'h00);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule